// File: doc/BRIEF.md
# User-Mode Base/Mask Address Translator

This block sits between a 24-bit CPU address bus (word addressed, bit 0 carried by byte strobes elsewhere) and the DRAM. Supervisor software confines a user program to one power-of-two window of DRAM. It does so by writing a base and a mask into four write-only configuration registers. For every user-mode cycle, the block keeps the logical page bits that the mask allows, ORs in the base, and sends the result on as the physical address. A user cycle that reaches past the window, or that touches the upper half of the address space outside the one slot open to user code, is flagged for a bus error.

Supervisor cycles are never translated or checked. The registers capture only the upper data byte. Results are registered, so the translated address and error flag appear one clock after the cycle is presented. Reset gives identity mapping over the lower 4 MiB.

Top module: `uwin_mapper`

## Requirements
- R1: A supervisor cycle (`cyc_super`=1) returns `xl_addr` equal to `cyc_addr` and `xl_berr`=0, for any address.
- R2: A user cycle below 800000h returns `xl_addr[23]`=0, `xl_addr[22:12]` = (`cyc_addr[22:12]` AND {0, mask[21:12]}) OR base[22:12], and `xl_addr[11:1]` = `cyc_addr[11:1]`.
- R3: A user cycle below 800000h raises `xl_berr` when any of `cyc_addr[22:12]` is 1 where the mask (bit 22 always taken as 0) is 0.
- R4: A user cycle at or above 800000h raises `xl_berr`, except inside F80000h–F9FFFFh, where it passes untranslated with no error.
- R5: A supervisor write cycle (`cyc_rd`=0) to word FE0000h/FE0002h/FE0004h/FE0006h loads `cyc_dhi` into base[19:12], base[22:20], mask[19:12] and mask[21:20] respectively, with `cyc_dhi` bit 0 going to the lowest field bit and surplus high bits dropped.
- R6: After reset, the mask is all ones and the base is zero, so user addresses below 400000h map to themselves.
- R7: Reads, and user-mode writes, to the register words leave the configuration unchanged. A user write there also raises `xl_berr`.
- R8: `xl_valid` is 1 exactly one clock after a cycle with `cyc_req`=1. `xl_berr` is 0 whenever `xl_valid` is 0.
- R9: A register write affects translation from the next presented cycle onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_req | input | 1 | A bus cycle is presented this clock |
| cyc_rd | input | 1 | 1 = read, 0 = write |
| cyc_super | input | 1 | Supervisor flag (FC2) |
| cyc_addr | input | 23 | Logical word address, bits 23:1 |
| cyc_dhi | input | 8 | Data bus bits 15:8 |
| xl_valid | output | 1 | Result of the previous cycle is present |
| xl_addr | output | 23 | Physical word address, bits 23:1 |
| xl_berr | output | 1 | Bus error request |

## Verification
The bench first runs directed cycles, then a long pseudo-random stream. Each cycle is checked against a behavioural model. The directed cycles cover several cases. Supervisor pass-through at arbitrary addresses separates R1 from the user path. User addresses just inside and just outside a programmed window tell a correct mask check from a wrong one. A window moved by a base write exposes errors in how the base is ORed in or how its bits are placed. Writes of 0xFF to the high halves show that surplus bits are dropped. User writes to the register words, and supervisor reads of them, show that they are ignored by the translation that follows. Addresses in the open slot, beside it, and in the reserved upper region separate the R4 cases. The random stream mixes all of these with reconfiguration, so stale-register and latency faults show up.

// File: rtl/uwin_pkg.sv
package uwin_pkg;
  localparam int unsigned BYTE_W = 8;

  // Register word index within the configuration block (cyc_addr[2:1]).
  typedef enum logic [1:0] {
    CFG_BASE_LO = 2'd0,
    CFG_BASE_HI = 2'd1,
    CFG_MASK_LO = 2'd2,
    CFG_MASK_HI = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/uwin_cfg_regs.sv
module uwin_cfg_regs #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned PAGE_LSB = 12,
  parameter logic [31:0] REG_BASE = 32'h00FE_0000,
  localparam int unsigned BASE_W    = ADDR_W - 1 - PAGE_LSB,
  localparam int unsigned MASK_W    = BASE_W - 1,
  localparam int unsigned LO_W      = uwin_pkg::BYTE_W,
  localparam int unsigned BASE_HI_W = BASE_W - LO_W,
  localparam int unsigned MASK_HI_W = MASK_W - LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_req,
  input  logic              cyc_rd,
  input  logic              cyc_super,
  input  logic [ADDR_W-1:1] cyc_addr,
  input  logic [LO_W-1:0]   cyc_dhi,
  output logic [BASE_W-1:0] base_q,
  output logic [MASK_W-1:0] mask_q
);
  import uwin_pkg::*;

  logic     blk_hit;
  logic     wr_en;
  cfg_sel_e sel;

  assign blk_hit = (cyc_addr[ADDR_W-1:3] == REG_BASE[ADDR_W-1:3]);
  assign wr_en   = cyc_req && cyc_super && !cyc_rd && blk_hit;
  assign sel     = cfg_sel_e'(cyc_addr[2:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      case (sel)
        CFG_BASE_LO: base_q[LO_W-1:0]      <= cyc_dhi;
        CFG_BASE_HI: base_q[BASE_W-1:LO_W] <= cyc_dhi[BASE_HI_W-1:0];
        CFG_MASK_LO: mask_q[LO_W-1:0]      <= cyc_dhi;
        CFG_MASK_HI: mask_q[MASK_W-1:LO_W] <= cyc_dhi[MASK_HI_W-1:0];
        default: ;
      endcase
    end
  end

  // R7: without a supervisor write the configuration holds.
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(cyc_req && cyc_super && !cyc_rd) |=> ($stable(base_q) && $stable(mask_q)));

  // R5: a supervisor write to the low mask word lands in mask bits 19:12.
  assert_mask_lo_load_R5: assert property (@(posedge clk) disable iff (rst)
    (cyc_req && cyc_super && !cyc_rd &&
     cyc_addr == REG_BASE[ADDR_W-1:1] + (ADDR_W-1)'(2))
    |=> (mask_q[LO_W-1:0] == $past(cyc_dhi)));
endmodule

// File: rtl/uwin_xlate.sv
module uwin_xlate #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned PAGE_LSB  = 12,
  parameter logic [31:0] SLOT_BASE = 32'h00F8_0000,
  parameter int unsigned SLOT_LSB  = 17,
  localparam int unsigned BASE_W   = ADDR_W - 1 - PAGE_LSB,
  localparam int unsigned MASK_W   = BASE_W - 1
) (
  input  logic              cyc_super,
  input  logic [ADDR_W-1:1] cyc_addr,
  input  logic [BASE_W-1:0] base_q,
  input  logic [MASK_W-1:0] mask_q,
  output logic [ADDR_W-1:1] x_addr,
  output logic              x_err
);
  logic [BASE_W-1:0] page;
  logic [BASE_W-1:0] keep;
  logic [BASE_W-1:0] phys_page;
  logic              hi_half;
  logic              in_slot;
  logic              over_win;

  assign page      = cyc_addr[ADDR_W-2:PAGE_LSB];
  assign keep      = {1'b0, mask_q};
  assign phys_page = (page & keep) | base_q;
  assign over_win  = |(page & ~keep);
  assign hi_half   = cyc_addr[ADDR_W-1];
  assign in_slot   = (cyc_addr[ADDR_W-1:SLOT_LSB] == SLOT_BASE[ADDR_W-1:SLOT_LSB]);

  always_comb begin
    x_addr = cyc_addr;
    x_err  = 1'b0;
    if (!cyc_super) begin
      if (!hi_half) begin
        x_addr = {1'b0, phys_page, cyc_addr[PAGE_LSB-1:1]};
        x_err  = over_win;
      end else begin
        x_err  = !in_slot;
      end
    end
  end
endmodule

// File: rtl/uwin_mapper.sv
module uwin_mapper #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned PAGE_LSB  = 12,
  parameter logic [31:0] REG_BASE  = 32'h00FE_0000,
  parameter logic [31:0] SLOT_BASE = 32'h00F8_0000,
  parameter int unsigned SLOT_LSB  = 17,
  localparam int unsigned BASE_W   = ADDR_W - 1 - PAGE_LSB,
  localparam int unsigned MASK_W   = BASE_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_req,
  input  logic              cyc_rd,
  input  logic              cyc_super,
  input  logic [ADDR_W-1:1] cyc_addr,
  input  logic [7:0]        cyc_dhi,
  output logic              xl_valid,
  output logic [ADDR_W-1:1] xl_addr,
  output logic              xl_berr
);
  logic [BASE_W-1:0] base_q;
  logic [MASK_W-1:0] mask_q;
  logic [ADDR_W-1:1] x_addr;
  logic              x_err;

  uwin_cfg_regs #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .REG_BASE(REG_BASE)
  ) cfg_i (
    .clk(clk), .rst(rst), .cyc_req(cyc_req), .cyc_rd(cyc_rd),
    .cyc_super(cyc_super), .cyc_addr(cyc_addr), .cyc_dhi(cyc_dhi),
    .base_q(base_q), .mask_q(mask_q)
  );

  uwin_xlate #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB),
    .SLOT_BASE(SLOT_BASE), .SLOT_LSB(SLOT_LSB)
  ) xl_i (
    .cyc_super(cyc_super), .cyc_addr(cyc_addr),
    .base_q(base_q), .mask_q(mask_q),
    .x_addr(x_addr), .x_err(x_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_valid <= 1'b0;
      xl_berr  <= 1'b0;
      xl_addr  <= '0;
    end else begin
      xl_valid <= cyc_req;
      xl_berr  <= cyc_req & x_err;
      if (cyc_req) xl_addr <= x_addr;
    end
  end

  assert_super_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc_req && cyc_super) |=> (!xl_berr && xl_addr == $past(cyc_addr)));

  assert_dram_top_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (cyc_req && !cyc_super && !cyc_addr[ADDR_W-1]) |=> (xl_berr || !xl_addr[ADDR_W-1]));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    cyc_req |=> (xl_addr[PAGE_LSB-1:1] == $past(cyc_addr[PAGE_LSB-1:1])));

  assert_user_high_err_R4: assert property (@(posedge clk) disable iff (rst)
    (cyc_req && !cyc_super && cyc_addr[ADDR_W-1] &&
     cyc_addr[ADDR_W-1:SLOT_LSB] != SLOT_BASE[ADDR_W-1:SLOT_LSB]) |=> xl_berr);

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    cyc_req |=> xl_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !cyc_req |=> (!xl_valid && !xl_berr));
endmodule

// File: tb/uwin_mapper_tb_top.sv
module uwin_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_req = 1'b0;
  logic        cyc_rd = 1'b1;
  logic        cyc_super = 1'b0;
  logic [23:1] cyc_addr = '0;
  logic [7:0]  cyc_dhi = '0;
  logic        xl_valid;
  logic [23:1] xl_addr;
  logic        xl_berr;

  int checks = 0;
  int errors = 0;
  int m_base = 0;
  int m_mask = 'h3FF;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  uwin_mapper dut_i (
    .clk(clk), .rst(rst), .cyc_req(cyc_req), .cyc_rd(cyc_rd),
    .cyc_super(cyc_super), .cyc_addr(cyc_addr), .cyc_dhi(cyc_dhi),
    .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_berr(xl_berr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed >> 8);
  endfunction

  // Behavioural model: byte address a, returns expected byte address and error.
  task automatic model(input bit sup, input int a, output int oa, output bit err);
    int pg, m;
    if (sup) begin oa = a; err = 0; end
    else if (a < 'h800000) begin
      pg  = (a >> 12) & 'h7FF;
      m   = m_mask & 'h3FF;
      oa  = ((((pg & m) | m_base) & 'h7FF) << 12) | (a & 'hFFF);
      err = ((pg & ~m) & 'h7FF) != 0;
    end else if (a >= 'hF80000 && a < 'hFA0000) begin oa = a; err = 0; end
    else begin oa = a; err = 1; end
  endtask

  // One cycle: drive at negedge, compare one clock later at the next negedge.
  task automatic cyc(input string tag, input bit req, input bit rd,
                     input bit sup, input int a, input int d);
    int  oa;
    bit  err;
    model(sup, a, oa, err);
    cyc_req = req; cyc_rd = rd; cyc_super = sup;
    cyc_addr = 23'(a >> 1); cyc_dhi = 8'(d);
    if (req && sup && !rd && a >= 'hFE0000 && a < 'hFE0008) begin
      case ((a >> 1) & 3)
        0: m_base = (m_base & 'h700) | (d & 'hFF);
        1: m_base = (m_base & 'h0FF) | ((d & 7) << 8);
        2: m_mask = (m_mask & 'h300) | (d & 'hFF);
        default: m_mask = (m_mask & 'h0FF) | ((d & 3) << 8);
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    cyc_req = 1'b0;
    chk({tag, " R8 valid"}, int'(xl_valid), int'(req));
    if (req) begin
      chk({tag, " berr"}, int'(xl_berr), int'(err));
      chk({tag, " addr"}, int'({xl_addr, 1'b0}), oa & 'hFFFFFE);
    end else begin
      chk({tag, " R8 idle berr"}, int'(xl_berr), 0);
    end
  endtask

  task automatic wr(input int idx, input int d);
    cyc("R5 cfg write", 1, 0, 1, 'hFE0000 + 2 * idx, d);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R6 reset valid", int'(xl_valid), 0);
    chk("R6 reset berr", int'(xl_berr), 0);

    cyc("R6 identity", 1, 1, 0, 'h012346, 0);
    cyc("R6 identity top", 1, 1, 0, 'h3FFFFE, 0);
    cyc("R3 bit22 at reset", 1, 1, 0, 'h400000, 0);
    cyc("R1 super pass", 1, 0, 1, 'hABCDEE, 0);
    cyc("R1 super low", 1, 1, 1, 'h7FF000, 0);
    cyc("R8 idle", 0, 1, 0, 'h000100, 0);

    // 1 MiB window at 100000h
    wr(0, 'h00); wr(1, 'h01); wr(2, 'hFF); wr(3, 'h00);
    cyc("R2 R9 window", 1, 1, 0, 'h0ABCDE, 0);
    cyc("R3 past window", 1, 1, 0, 'h100000, 0);
    cyc("R3 edge inside", 1, 0, 0, 'h0FFFFE, 0);

    // ignored register accesses
    cyc("R7 user cfg write", 1, 0, 0, 'hFE0002, 'h07);
    cyc("R7 super cfg read", 1, 1, 1, 'hFE0000, 'h55);
    cyc("R7 after ignored", 1, 1, 0, 'h012344, 0);

    // slot and high region
    cyc("R4 slot", 1, 1, 0, 'hF81234, 0);
    cyc("R4 slot end", 1, 0, 0, 'hF9FFFE, 0);
    cyc("R4 beside slot", 1, 1, 0, 'hFA0000, 0);
    cyc("R4 reserved", 1, 1, 0, 'h900000, 0);
    cyc("R4 mfp", 1, 1, 0, 'hF00000, 0);

    // surplus high bits dropped, base moved
    wr(3, 'hFF); wr(1, 'hFF); wr(0, 'h00);
    cyc("R5 mask hi", 1, 1, 0, 'h3FF000, 0);
    cyc("R5 base hi", 1, 1, 0, 'h001000, 0);
    cyc("R3 bit22 still", 1, 1, 0, 'h400000, 0);
    wr(2, 'h0F); wr(1, 'h02); wr(0, 'h30);
    cyc("R9 next cycle", 1, 1, 0, 'h00F002, 0);

    for (int i = 0; i < 2000; i++) begin
      int r, a, k;
      r = rnd();
      k = r & 15;
      a = rnd() & 'hFFFFFE;
      if (k < 2)       cyc("R5 rnd cfg", 1, 0, 1, 'hFE0000 + (r & 6), rnd());
      else if (k < 3)  cyc("R7 rnd cfg", 1, (r >> 4) & 1, (r >> 5) & 1, 'hFE0000 + (r & 6), rnd());
      else if (k < 4)  cyc("R8 rnd idle", 0, 1, 0, a, 0);
      else if (k < 6)  cyc("R1 rnd", 1, (r >> 4) & 1, 1, a, 0);
      else if (k < 8)  cyc("R4 rnd", 1, (r >> 4) & 1, 0, a | 'h800000, 0);
      else             cyc("R2 R3 rnd", 1, (r >> 4) & 1, 0, a & (((r >> 6) & 1) ? 'h7FFFFE : 'h0FFFFE), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule